// File: doc/BRIEF.md
# Triggered Byte-Parallel DAC Streamer

This block feeds an external converter that has an 8-bit parallel data input and a separate clock pin. A host writes 32-bit sample words into an eight-entry transmit queue. The sequencer splits each word into four bytes and puts them on the data bus one at a time. It raises the converter clock after each byte settles, and the converter latches the byte on that rising edge. All sequencing advances on a tick. The tick comes from a programmable divider on the system clock.

When the block is enabled, it first clocks a single zero byte into the converter. It then parks with the clock low and waits for a start trigger. The trigger is a level flag shared with other engines. The block pulses a clear strobe when it takes the trigger. After that it streams words back to back with no gap. If the queue runs dry, the block stalls with the clock low and the last byte held, and it resumes when a new word arrives. Dropping enable returns the block to the zero-byte preamble. The queue contents are kept.

Top module: `dac_streamer`

## Requirements
- R1: When enable rises after reset, the clock output makes exactly one rising edge while the data bus is 0x00, and then returns low.
- R2: After the preamble, the clock stays low and no further rising edge occurs while `trig_i` is low.
- R3: A high `trig_i` seen on a tick while waiting produces a `trig_clr_o` pulse exactly one cycle wide, and byte streaming begins.
- R4: Each queued word is sent as four bytes, least-significant byte first: bits [7:0], then [15:8], then [23:16], then [31:24]. Words are sent in the order they were written.
- R5: During streaming, the clock is high for 2 ticks and low for 2 ticks, so rising edges are 4 ticks apart across word boundaries. The data bus does not change while the clock is high.
- R6: One tick occurs every `div_i`+1 system clock cycles. With `div_i`=2, the clock is high for 6 cycles and rising edges are 12 cycles apart.
- R7: The queue holds 8 words. `wr_ready_o` is low when the queue is full, and a write offered while it is low is dropped.
- R8: If the queue is empty when a new word is needed, the clock stays low and the data bus holds the last byte until a word is written. Streaming then resumes with that word's low byte.
- R9: While `en_i` is low, the clock output is low and the data bus is 0x00. Enabling again repeats the preamble of R1 and the trigger wait of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low forces the preamble state |
| div_i | input | 16 | Tick divider; one tick every div_i+1 cycles |
| wr_valid_i | input | 1 | Host offers a word |
| wr_data_i | input | 32 | Host word (four bytes, low byte first) |
| wr_ready_o | output | 1 | Queue has room; the offered word is taken when high |
| trig_i | input | 1 | Shared start-trigger flag |
| trig_clr_o | output | 1 | One-cycle strobe that clears the trigger flag |
| dac_data_o | output | 8 | Parallel data bus to the converter |
| dac_clk_o | output | 1 | Converter clock; data is latched on its rising edge |

## Verification
The streaming path is tested with three input patterns.

- **Full queue of distinct words.** The bench fills the queue with eight words whose bytes count upward from 0x01 to 0x20. This shows whether byte order, word order and back-to-back timing across word boundaries are correct. The bench also offers a ninth word, which must be dropped.
- **Single word after a stall.** This shows whether the block holds the last byte during an underflow and resumes on the correct byte.
- **Pair of words with a nonzero divider.** This shows whether phase lengths scale with the tick rate and do not stay fixed in system cycles.

Disabling and re-enabling the block separates a true return to the preamble from a resume of the stream.

// File: rtl/dac_stream_pkg.sv
package dac_stream_pkg;
  typedef enum logic [2:0] {
    ST_PRE_LO,
    ST_PRE_HI,
    ST_WAIT,
    ST_LOW,
    ST_HIGH
  } seq_state_e;
endpackage

// File: rtl/dac_tick_div.sv
module dac_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= so that lowering div_i mid-count cannot skip a wrap
  assign tick_o = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || tick_o)    cnt_q <= '0;
    else                         cnt_q <= cnt_q + DIV_W'(1);
  end

  // R6
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/dac_word_fifo.sv
module dac_word_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ready_o,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [WORD_W-1:0] head_o
);
  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW:0]       wptr_q, rptr_q, count;
  logic              do_push, do_pop;

  assign count   = wptr_q - rptr_q;
  assign ready_o = count != (AW+1)'(DEPTH);
  assign empty_o = count == '0;
  assign do_push = push_i && ready_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + (AW+1)'(1);
      if (do_pop)  rptr_q <= rptr_q + (AW+1)'(1);
    end
  end

  // R7
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !pop_i) |=> $stable(count));
  // R7
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/dac_byte_seq.sv
module dac_byte_seq
  import dac_stream_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              trig_i,
  output logic              trig_clr_o,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_head_i,
  output logic              fifo_pop_o,
  output logic [BYTE_W-1:0] dac_data_o,
  output logic              dac_clk_o
);
  localparam int NB = WORD_W / BYTE_W;
  localparam int IW = $clog2(NB);

  seq_state_e        state_q;
  logic              ph_q;
  logic [IW-1:0]     idx_q;
  logic [WORD_W-1:0] word_q;
  logic [BYTE_W-1:0] data_q;
  logic              clk_q, clr_q;
  logic              need_byte, starved;
  logic [BYTE_W-1:0] cur_byte;

  assign need_byte  = en_i && tick_i && state_q == ST_LOW && !ph_q;
  assign starved    = idx_q == '0 && fifo_empty_i;
  assign fifo_pop_o = need_byte && !starved && idx_q == '0;
  assign cur_byte   = (idx_q == '0) ? fifo_head_i[BYTE_W-1:0]
                                    : word_q[idx_q*BYTE_W +: BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PRE_LO;
      ph_q    <= 1'b0;
      idx_q   <= '0;
      word_q  <= '0;
      data_q  <= '0;
      clk_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_PRE_LO;
      ph_q    <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
      clk_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_PRE_LO: begin
            data_q  <= '0;
            clk_q   <= 1'b1;
            state_q <= ST_PRE_HI;
          end
          ST_PRE_HI: begin
            clk_q   <= 1'b0;
            state_q <= ST_WAIT;
          end
          ST_WAIT: begin
            if (trig_i) begin
              clr_q   <= 1'b1;
              ph_q    <= 1'b0;
              state_q <= ST_LOW;
            end
          end
          ST_LOW: begin
            if (!ph_q) begin
              if (!starved) begin
                data_q <= cur_byte;
                if (idx_q == '0) word_q <= fifo_head_i;
                idx_q  <= idx_q + IW'(1);
                ph_q   <= 1'b1;
              end
            end else begin
              ph_q    <= 1'b0;
              clk_q   <= 1'b1;
              state_q <= ST_HIGH;
            end
          end
          ST_HIGH: begin
            if (!ph_q) ph_q <= 1'b1;
            else begin
              ph_q    <= 1'b0;
              clk_q   <= 1'b0;
              state_q <= ST_LOW;
            end
          end
          default: state_q <= ST_PRE_LO;
        endcase
      end
    end
  end

  assign dac_data_o = data_q;
  assign dac_clk_o  = clk_q;
  assign trig_clr_o = clr_q;

  // R5
  data_stable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_clk_o && $past(dac_clk_o)) |-> $stable(dac_data_o));
  // R3
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_clr_o |=> !trig_clr_o);
  // R9
  disable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!dac_clk_o && dac_data_o == '0));
  // R2
  wait_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> !dac_clk_o);
  // R8
  starve_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_LOW && !ph_q && starved) |=> $stable(dac_data_o));
endmodule

// File: rtl/dac_streamer.sv
module dac_streamer #(
  parameter int WORD_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              trig_i,
  output logic              trig_clr_o,
  output logic [BYTE_W-1:0] dac_data_o,
  output logic              dac_clk_o
);
  logic              tick, fifo_empty, fifo_pop;
  logic [WORD_W-1:0] fifo_head;

  dac_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_i(div_i), .tick_o(tick)
  );

  dac_word_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(wr_valid_i), .data_i(wr_data_i), .ready_o(wr_ready_o),
    .pop_i(fifo_pop), .empty_o(fifo_empty), .head_o(fifo_head)
  );

  dac_byte_seq #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick),
    .trig_i(trig_i), .trig_clr_o(trig_clr_o),
    .fifo_empty_i(fifo_empty), .fifo_head_i(fifo_head), .fifo_pop_o(fifo_pop),
    .dac_data_o(dac_data_o), .dac_clk_o(dac_clk_o)
  );
endmodule

// File: tb/tb_dac_streamer.sv
module tb_dac_streamer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] div = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, trig = 1'b0, trig_clr, dclk;
  logic [7:0]  ddata;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, nr = 0, last_hi = 0, last_rise = 0;
  logic [7:0] rd [128];
  int         rt [128];
  logic       prev_clk = 1'b0;

  always #5 clk = ~clk;

  dac_streamer dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .trig_i(trig), .trig_clr_o(trig_clr), .dac_data_o(ddata), .dac_clk_o(dclk)
  );

  always @(negedge clk) begin
    cyc++;
    if (dclk && !prev_clk) begin
      if (nr < 128) begin rd[nr] = ddata; rt[nr] = cyc; end
      last_rise = cyc;
      nr++;
    end
    if (!dclk && prev_clk) last_hi = cyc - last_rise;
    prev_clk = dclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FIFO-stream FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [31:0] w, output bit acc);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = w; acc = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    wait_cyc(3);
    chk(dclk == 1'b0, "R9 reset clk", dclk, 0);
    chk(ddata == 8'h00, "R9 reset data", ddata, 0);
    chk(trig_clr == 1'b0, "R3 reset clr", trig_clr, 0);
    chk(wr_ready == 1'b1, "R7 reset ready", wr_ready, 1);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic t_fill;
    int acc_n = 0;
    bit a;
    for (int k = 0; k < 9; k++) begin
      push({8'(4*k+4), 8'(4*k+3), 8'(4*k+2), 8'(4*k+1)}, a);
      if (a) acc_n++;
    end
    chk(acc_n == 8, "R7 accepted words", acc_n, 8);
    chk(wr_ready == 1'b0, "R7 ready when full", wr_ready, 0);
  endtask

  task automatic t_preamble;
    int base = nr;
    en = 1'b1;
    wait_cyc(20);
    chk(nr - base == 1, "R1 preamble edges", nr - base, 1);
    chk(rd[base] == 8'h00, "R1 preamble byte", rd[base], 0);
    chk(dclk == 1'b0, "R1 clk back low", dclk, 0);
    wait_cyc(40);
    chk(nr - base == 1, "R2 no edge without trigger", nr - base, 1);
    chk(dclk == 1'b0, "R2 clk low while waiting", dclk, 0);
  endtask

  task automatic t_stream;
    int base = nr, to = 0, w = 0;
    trig = 1'b1;
    while (!trig_clr && to < 50) begin @(negedge clk); to++; end
    chk(trig_clr == 1'b1, "R3 clear strobe seen", trig_clr, 1);
    trig = 1'b0;
    while (trig_clr && w < 10) begin @(negedge clk); w++; end
    chk(w == 1, "R3 clear strobe width", w, 1);
    to = 0;
    while (nr < base + 32 && to < 400) begin @(negedge clk); to++; end
    chk(nr - base == 32, "R4 bytes streamed", nr - base, 32);
    for (int i = 0; i < 32; i++)
      chk(rd[base+i] == 8'(i+1), "R4 byte order", rd[base+i], i+1);
    for (int i = 1; i < 32; i++)
      chk(rt[base+i] - rt[base+i-1] == 4, "R5 edge spacing", rt[base+i] - rt[base+i-1], 4);
    wait_cyc(10);
    chk(last_hi == 2, "R5 high length", last_hi, 2);
    chk(wr_ready == 1'b1, "R7 room after drain", wr_ready, 1);
  endtask

  task automatic t_stall;
    int base = nr, to = 0;
    bit a;
    wait_cyc(40);
    chk(nr == base, "R8 no edge when empty", nr - base, 0);
    chk(dclk == 1'b0, "R8 clk low in stall", dclk, 0);
    chk(ddata == 8'h20, "R8 last byte held", ddata, 8'h20);
    push(32'hA4A3A2A1, a);
    while (nr < base + 4 && to < 100) begin @(negedge clk); to++; end
    chk(nr - base == 4, "R8 resumed bytes", nr - base, 4);
    chk(rd[base] == 8'hA1 && rd[base+3] == 8'hA4, "R8 resume order", rd[base], 8'hA1);
    wait_cyc(30);
    chk(ddata == 8'hA4 && dclk == 1'b0, "R8 hold after resume", ddata, 8'hA4);
  endtask

  task automatic t_div;
    int base, to = 0;
    bit a;
    div = 16'd2;
    wait_cyc(5);
    base = nr;
    push(32'hB4B3B2B1, a);
    push(32'hB8B7B6B5, a);
    while (nr < base + 8 && to < 400) begin @(negedge clk); to++; end
    chk(nr - base == 8, "R6 bytes with divider", nr - base, 8);
    for (int i = 1; i < 8; i++)
      chk(rt[base+i] - rt[base+i-1] == 12, "R6 edge spacing", rt[base+i] - rt[base+i-1], 12);
    wait_cyc(20);
    chk(last_hi == 6, "R6 high length", last_hi, 6);
    chk(rd[base+4] == 8'hB5, "R4 second word low byte", rd[base+4], 8'hB5);
    div = '0;
  endtask

  task automatic t_disable;
    int base;
    en = 1'b0;
    wait_cyc(2);
    chk(dclk == 1'b0, "R9 clk low when disabled", dclk, 0);
    chk(ddata == 8'h00, "R9 data zero when disabled", ddata, 0);
    base = nr;
    en = 1'b1;
    wait_cyc(30);
    chk(nr - base == 1 && rd[base] == 8'h00, "R9 preamble repeats", nr - base, 1);
    chk(dclk == 1'b0, "R9 waits after re-enable", dclk, 0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_preamble();
    t_stream();
    t_stall();
    t_div();
    t_disable();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule